// File: doc/BRIEF.md
# Programmable UART baud-rate generator

This block turns a fixed 14.7456 MHz reference clock into the timing strobes that a UART's shifters need. Software loads a 16-bit divisor into two byte-wide registers over a small register bus. The block then emits a one-cycle oversampling tick at 16 times the baud rate, so the baud rate equals the reference clock divided by 16 × divisor. A divisor of 1 gives 921,600 baud and a divisor of 8 gives 115,200 baud. A second strobe, the baud tick, fires once in every 16 oversampling ticks for logic that works at bit rate.

The two divisor bytes share bus addresses with a data-holding register and an interrupt-enable register. Bit 7 of the line-control register chooses which pair a bus access reaches. Here, the data-holding and interrupt-enable registers are plain storage. After reset the divisor is 0x0002. When both bytes are zero the divider stops and no ticks come out. Any write to a divisor byte restarts the divider, so the new period applies from that write.

The divider is a two-state machine. In state S_RUN a down-counter counts from divisor−1 to zero, and the oversampling tick is raised while the count is zero. The counter then reloads. In state S_HALT the counter is frozen and no tick is raised. A divisor write takes the transition S_RUN→S_HALT or S_HALT→S_HALT when the new value is zero. It takes S_HALT→S_RUN or S_RUN→S_RUN (counter reloaded) when the new value is non-zero. With no divisor write, each state stays where it is.

Top module: `uart_brg`

## Requirements
- R1: After reset the divisor is 0x0002 (high byte 0x00, low byte 0x02), the line-control register reads 0x00 and the data-holding and interrupt-enable registers read 0x00.
- R2: Address 2 is the line-control register. It can be written and read at all times, and its bit 7 is the divisor-access bit. Address 3 reads 0x00 and ignores writes.
- R3: While bit 7 of line-control is 1, address 0 writes and reads the divisor low byte (bits 7:0) and address 1 writes and reads the divisor high byte (bits 15:8).
- R4: While bit 7 of line-control is 0, addresses 0 and 1 reach the data-holding and interrupt-enable registers. Writes there leave the divisor and the tick period unchanged.
- R5: With a divisor D from 2 to 65535, consecutive oversampling ticks are exactly D clock cycles apart, and each tick lasts one cycle.
- R6: With a divisor of 1, the oversampling tick is high in every cycle.
- R7: With a divisor of 0, no oversampling tick and no baud tick are emitted.
- R8: A write to either divisor byte at clock edge E restarts the divider. The first tick after it is high in the cycle that begins D−1 edges after E.
- R9: The baud tick is high together with every 16th oversampling tick, counted from the last divisor write, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 14.7456 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| os_tick | output | 1 | Oversampling strobe at 16 × baud rate |
| baud_tick | output | 1 | Strobe at the baud rate |

## Verification
The hardest case to reach is the largest divisor, 65535. It needs two byte writes and then a wait of more than 65,000 cycles per tick. The bench loads it high byte first and low byte last, so that the restart happens at a known edge. It then counts the cycles to the first tick and to the second. Locked-out writes are harder to see: their only visible effect is the absence of a change. So the bench checks them in two ways. It measures the tick period right after the ignored writes, and it sets the access bit again to read back both divisor bytes.

// File: rtl/uart_brg_pkg.sv
package uart_brg_pkg;
    localparam int REG_W  = 8;
    localparam int DIV_W  = 2 * REG_W;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_LOW  = 2'd0;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
    localparam logic [ADDR_W-1:0] A_LINE = 2'd2;

    localparam int ACCESS_BIT = 7;

    typedef enum logic [0:0] {
        S_HALT = 1'b0,
        S_RUN  = 1'b1
    } brg_state_e;
endpackage

// File: rtl/brg_regs.sv
module brg_regs
    import uart_brg_pkg::*;
#(
    parameter logic [DIV_W-1:0] RST_DIV = 16'h0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [DIV_W-1:0]  divisor,
    output logic              div_wr,
    output logic [DIV_W-1:0]  div_next
);
    logic [REG_W-1:0] line_q, hold_q, ien_q, lo_q, hi_q;
    logic             access;

    assign access   = line_q[ACCESS_BIT];
    assign divisor  = {hi_q, lo_q};
    assign div_wr   = wr && access && (addr == A_LOW || addr == A_HIGH);
    assign div_next = {(addr == A_HIGH) ? wdata : hi_q,
                       (addr == A_LOW)  ? wdata : lo_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            hold_q <= '0;
            ien_q  <= '0;
            lo_q   <= RST_DIV[REG_W-1:0];
            hi_q   <= RST_DIV[DIV_W-1:REG_W];
        end else if (wr) begin
            unique case (addr)
                A_LOW:   if (access) lo_q <= wdata; else hold_q <= wdata;
                A_HIGH:  if (access) hi_q <= wdata; else ien_q  <= wdata;
                A_LINE:  line_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            A_LOW:   rdata = access ? lo_q : hold_q;
            A_HIGH:  rdata = access ? hi_q : ien_q;
            A_LINE:  rdata = line_q;
            default: rdata = '0;
        endcase
    end

    // R4: a write while the access bit is clear never moves the divisor
    a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !access && (addr == A_LOW || addr == A_HIGH)) |=> $stable(divisor));
endmodule

// File: rtl/brg_divider.sv
module brg_divider
    import uart_brg_pkg::*;
#(
    parameter logic [DIV_W-1:0] RST_DIV = 16'h0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    input  logic [DIV_W-1:0] restart_val,
    output logic             tick
);
    brg_state_e       state_q, state_n;
    logic [DIV_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (restart) begin
            if (restart_val == '0) begin
                state_n = S_HALT;
                cnt_n   = '0;
            end else begin
                state_n = S_RUN;
                cnt_n   = restart_val - 1'b1;
            end
        end else begin
            unique case (state_q)
                S_HALT: cnt_n = cnt_q;
                S_RUN:  cnt_n = (cnt_q == '0) ? divisor - 1'b1 : cnt_q - 1'b1;
                default: cnt_n = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= (RST_DIV == '0) ? S_HALT : S_RUN;
            cnt_q   <= (RST_DIV == '0) ? '0 : RST_DIV - 1'b1;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        unique case (state_q)
            S_RUN:   tick = (cnt_q == '0);
            default: tick = 1'b0;
        endcase
    end

    // R7: a zero divisor keeps the strobe quiet
    a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !tick);
    // R5: above a divisor of one, a tick is never followed by another at once
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > 16'd1 && !restart) |=> !tick);
    // R6: a divisor of one gives a tick every cycle
    a_r6_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == 16'd1) |-> tick);
endmodule

// File: rtl/brg_baud_count.sv
module brg_baud_count #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os_tick,
    output logic baud_tick
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (os_tick) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

    assign baud_tick = os_tick && (phase_q == LAST);

    // R9: the baud strobe only ever rides on an oversampling strobe
    a_r9_baud_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> os_tick);
endmodule

// File: rtl/uart_brg.sv
module uart_brg
    import uart_brg_pkg::*;
#(
    parameter logic [DIV_W-1:0] RST_DIV = 16'h0002,
    parameter int               OSR     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              os_tick,
    output logic              baud_tick
);
    logic [DIV_W-1:0] divisor, div_next;
    logic             div_wr;

    brg_regs #(.RST_DIV(RST_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .divisor(divisor),
        .div_wr(div_wr), .div_next(div_next)
    );

    brg_divider #(.RST_DIV(RST_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .restart(div_wr),
        .restart_val(div_next), .tick(os_tick)
    );

    brg_baud_count #(.OSR(OSR)) u_baud (
        .clk(clk), .rst_n(rst_n), .restart(div_wr), .os_tick(os_tick),
        .baud_tick(baud_tick)
    );

    // R7: nothing at the baud rate either when the divisor is zero
    a_r7_no_baud_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !baud_tick);
endmodule

// File: tb/sim_uart_brg.sv
module sim_uart_brg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       os_tick, baud_tick;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    uart_brg u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .os_tick(os_tick), .baud_tick(baud_tick)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one-cycle write; returns in the negedge of the cycle right after the write edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // high byte first, low byte last: the restart edge is the last write
    task automatic set_div(input int dv);
        wr(2'd2, 8'h80);
        wr(2'd1, dv[15:8]);
        wr(2'd0, dv[7:0]);
    endtask

    // called right after set_div (sample cycle k=0 after the restart edge)
    task automatic measure(input string req, input int dv);
        int k = 0;
        int gap = 0;
        while (!os_tick && k < 70000) begin
            @(negedge clk); k++;
        end
        check("R8", $sformatf("first tick offset, divisor %0d", dv), k, dv - 1);
        do begin
            @(negedge clk); gap++;
        end while (!os_tick && gap < 70000);
        check(req, $sformatf("tick interval, divisor %0d", dv), gap, dv);
    endtask

    initial begin
        logic [7:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(2'd2, d); check("R1", "line-control after reset", d, 0);
        rd(2'd0, d); check("R1", "data-holding after reset", d, 0);
        rd(2'd1, d); check("R1", "interrupt-enable after reset", d, 0);
        // R1: reset divisor 2 -> ticks alternate
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            if (os_tick) cnt++;
            @(negedge clk);
        end
        check("R1", "ticks in 20 cycles at reset divisor", cnt, 10);

        // R2 line-control readback, address 3 inert
        wr(2'd2, 8'h83);
        rd(2'd2, d); check("R2", "line-control readback", d, 8'h83);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R2", "address 3 reads zero", d, 0);
        rd(2'd0, d); check("R1", "reset divisor low byte", d, 2);
        rd(2'd1, d); check("R1", "reset divisor high byte", d, 0);

        // R3 divisor byte readback
        set_div(16'h1234);
        rd(2'd0, d); check("R3", "divisor low byte readback", d, 8'h34);
        rd(2'd1, d); check("R3", "divisor high byte readback", d, 8'h12);

        // R5, R8 tick intervals
        set_div(2);     measure("R5", 2);
        set_div(8);     measure("R5", 8);
        set_div(768);   measure("R5", 768);

        // R4 locked writes: divisor stays 8
        set_div(8);
        wr(2'd2, 8'h03);
        wr(2'd0, 8'h55);
        wr(2'd1, 8'h77);
        rd(2'd0, d); check("R4", "data-holding takes locked write", d, 8'h55);
        rd(2'd1, d); check("R4", "interrupt-enable takes locked write", d, 8'h77);
        while (!os_tick) @(negedge clk);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!os_tick && cnt < 100);
        check("R4", "interval after locked writes", cnt, 8);
        wr(2'd2, 8'h80);
        rd(2'd0, d); check("R4", "divisor low unchanged", d, 8);
        rd(2'd1, d); check("R4", "divisor high unchanged", d, 0);

        // R6 divisor one
        set_div(1);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            if (os_tick) cnt++;
            @(negedge clk);
        end
        check("R6", "ticks in 50 cycles at divisor 1", cnt, 50);

        // R9 baud tick with divisor 2: os ticks at k=1,3,..; baud at k=31, 63
        set_div(2);
        cnt = 0;
        for (int k = 0; k < 64; k++) begin
            if (baud_tick != ((k == 31) || (k == 63))) begin
                cnt++;
                $display("FAIL R9 baud tick at k=%0d: actual %0d expected %0d",
                         k, baud_tick, (k == 31) || (k == 63));
            end
            @(negedge clk);
        end
        checks++;
        if (cnt != 0) fails++;

        // R7 zero divisor
        set_div(0);
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            if (os_tick || baud_tick) cnt++;
            @(negedge clk);
        end
        check("R7", "ticks with divisor 0", cnt, 0);

        // R5 largest divisor
        set_div(65535); measure("R5", 65535);
        set_div(1);     measure("R6", 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule